// File: doc/BRIEF.md
# Time-Slot Serial Highway Port

This block is a full-duplex serial port for PCM links that carry time-division-multiplexed frames, such as the framed byte streams used by ISDN line devices. It generates its own bit clock and a one-bit-wide frame sync from the system clock. Transmit bytes are shifted out and receive bytes are shifted in at the same time. The active time slots in each frame are mapped in order onto the transmit and receive byte streams.

Each direction has a small byte FIFO with its own request/acknowledge pair towards a DMA engine. The bit rate, the frame length in bits and the number of active 8-bit slots are set by configuration inputs. These inputs stay stable while the port is enabled. The bit rate is the system clock divided by 2·(cfg_half+1), so a 50 MHz clock with cfg_half = 5 gives a little over 4 Mbit/s. If a FIFO cannot keep up, idle bytes go out on the line or incoming bytes are dropped, and a sticky flag records each event.

Top module: `tdm_highway`

## Requirements
- R1: While enabled, sclk has a period of 2·(cfg_half+1) system clocks. It is high for the first cfg_half+1 clocks of each bit and low for the rest. It goes high on the clock edge after en is first seen high.
- R2: A frame is cfg_frame+1 bits long. fsync is high for exactly the whole of bit 0 of every frame.
- R3: Bit n of a frame belongs to slot n/8, and slots 0 to cfg_chan are active. Each active slot sends the next byte from the transmit FIFO, most significant bit first. Each bit is held for a full sclk period starting at the rising edge. Bits outside active slots are sent as 1.
- R4: sdi is sampled once per bit, at the system clock edge that takes sclk low. When the last bit of an active slot is sampled, the eight samples of that slot form one byte, with the first sample as the MSB. That byte is written to the receive FIFO, and rx_data shows the oldest byte in the FIFO.
- R5: Each FIFO holds 4 bytes. tx_req is high while the transmit FIFO holds 2 or fewer bytes. rx_req is high while the receive FIFO holds 2 or more bytes.
- R6: If an active slot starts while the transmit FIFO is empty, the slot sends 8'hFF and tx_unf goes high and stays high until reset.
- R7: If a received byte completes while the receive FIFO is full, the byte is dropped and rx_ovf goes high and stays high until reset.
- R8: A tx_ack while the transmit FIFO is full writes nothing, and an rx_ack while the receive FIFO is empty removes nothing. Both cases can be seen in the later transmit and receive byte order.
- R9: During reset and while en is low, sclk and fsync are low and sdo is high. The next enable starts again at bit 0 of a frame, and FIFO contents and flags are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Port enable; low holds the line idle |
| cfg_half | input | DIV_W | Half bit period in system clocks, minus one |
| cfg_frame | input | FRM_W | Frame length in bits, minus one |
| cfg_chan | input | CH_W | Number of active slots, minus one |
| sclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync, high during bit 0 |
| sdo | output | 1 | Serial transmit data |
| sdi | input | 1 | Serial receive data |
| tx_req | output | 1 | Transmit FIFO wants data |
| tx_ack | input | 1 | Write tx_data into the transmit FIFO |
| tx_data | input | 8 | Byte from the DMA engine |
| rx_req | output | 1 | Receive FIFO has data to take |
| rx_ack | input | 1 | Remove the oldest receive byte |
| rx_data | output | 8 | Oldest receive byte |
| tx_unf | output | 1 | Sticky transmit underrun flag |
| rx_ovf | output | 1 | Sticky receive overrun flag |

## Verification
The hardest situations to reach are an underrun and an overrun that happen while the port keeps running, with the line timing intact afterwards. To get there, the stimulus first runs with the DMA side answering every request. It then withholds all acknowledges for several frames, so the transmit FIFO drains and the receive FIFO fills while the slot counters keep going. After that it disables the port in the middle of a frame and changes to a faster four-slot format. On restart it acknowledges on every cycle, which also pushes into a full FIFO and pops an empty one.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
   localparam int SLOT_BITS = 8;
   localparam int SB_W      = $clog2(SLOT_BITS);
   typedef logic [SLOT_BITS-1:0] slot_t;
endpackage

// File: rtl/tdm_fifo.sv
module tdm_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic [$clog2(DEPTH):0]     level
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          wr, rd;

   // acceptance judged on the level before this edge
   assign wr = push && (cnt != CW'(DEPTH));
   assign rd = pop  && (cnt != '0);

   always_ff @(posedge clk) begin
      if (wr) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (wr) wp <= wp + AW'(1);
         if (rd) rp <= rp + AW'(1);
         cnt <= cnt + CW'(wr) - CW'(rd);
      end
   end

   assign dout  = mem[rp];
   assign level = cnt;
endmodule

// File: rtl/tdm_timing.sv
module tdm_timing #(
   parameter int DIV_W = 8,
   parameter int FRM_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] cfg_half,
   input  logic [FRM_W-1:0] cfg_frame,
   output logic             run,
   output logic             low_half,
   output logic [FRM_W-1:0] bit_idx,
   output logic             fall_ev,
   output logic             start_ev,
   output logic [FRM_W-1:0] start_bit
);
   logic [DIV_W-1:0] ph;
   logic             tick;
   logic [FRM_W-1:0] nxt;

   assign tick      = en && run && (ph == cfg_half);
   assign fall_ev   = tick && !low_half;
   assign nxt       = (bit_idx == cfg_frame) ? '0 : bit_idx + FRM_W'(1);
   assign start_ev  = (en && !run) || (tick && low_half);
   assign start_bit = run ? nxt : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run      <= 1'b0;
         ph       <= '0;
         low_half <= 1'b0;
         bit_idx  <= '0;
      end else if (!en) begin
         run      <= 1'b0;
         ph       <= '0;
         low_half <= 1'b0;
         bit_idx  <= '0;
      end else if (!run) begin
         run <= 1'b1;
      end else if (tick) begin
         ph       <= '0;
         low_half <= ~low_half;
         if (low_half) bit_idx <= nxt;
      end else begin
         ph <= ph + DIV_W'(1);
      end
   end
endmodule

// File: rtl/tdm_highway.sv
module tdm_highway
   import tdm_pkg::*;
#(
   parameter int FIFO_DEPTH = 4,
   parameter int MAX_CH     = 64,
   parameter int DIV_W      = 8,
   localparam int CH_W      = $clog2(MAX_CH),
   localparam int FRM_W     = $clog2(MAX_CH * SLOT_BITS) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] cfg_half,
   input  logic [FRM_W-1:0] cfg_frame,
   input  logic [CH_W-1:0]  cfg_chan,
   output logic             sclk,
   output logic             fsync,
   output logic             sdo,
   input  logic             sdi,
   output logic             tx_req,
   input  logic             tx_ack,
   input  logic [7:0]       tx_data,
   output logic             rx_req,
   input  logic             rx_ack,
   output logic [7:0]       rx_data,
   output logic             tx_unf,
   output logic             rx_ovf
);
   localparam int CNT_W    = $clog2(FIFO_DEPTH) + 1;
   localparam int HALF_LVL = FIFO_DEPTH / 2;

   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two of at least 2");
   end
   if (MAX_CH < 2) begin : g_bad_ch
      $error("MAX_CH must be at least 2");
   end
   if (SLOT_BITS != 8) begin : g_bad_slot
      $error("slot width must match the 8-bit DMA data path");
   end

   logic             run, low_half, fall_ev, start_ev;
   logic [FRM_W-1:0] bit_idx, start_bit, chan_ext;
   logic             tx_slot_ok, rx_slot_ok, slot_head, slot_tail;
   logic [CNT_W-1:0] tx_cnt, rx_cnt;
   slot_t            tx_head, tx_sh, rx_sh, rx_byte;
   logic             tx_empty, rx_full;

   tdm_timing #(.DIV_W(DIV_W), .FRM_W(FRM_W)) u_tim (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .cfg_half  (cfg_half),
      .cfg_frame (cfg_frame),
      .run       (run),
      .low_half  (low_half),
      .bit_idx   (bit_idx),
      .fall_ev   (fall_ev),
      .start_ev  (start_ev),
      .start_bit (start_bit)
   );

   assign chan_ext   = FRM_W'(cfg_chan);
   assign tx_slot_ok = (start_bit >> SB_W) <= chan_ext;
   assign rx_slot_ok = (bit_idx >> SB_W) <= chan_ext;
   assign slot_head  = start_ev && (start_bit[SB_W-1:0] == '0);
   assign slot_tail  = fall_ev && rx_slot_ok &&
                       (bit_idx[SB_W-1:0] == SB_W'(SLOT_BITS - 1));
   assign rx_byte    = {rx_sh[SLOT_BITS-2:0], sdi};

   tdm_fifo #(.W(SLOT_BITS), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (tx_ack),
      .din   (tx_data),
      .pop   (slot_head && tx_slot_ok),
      .dout  (tx_head),
      .level (tx_cnt)
   );

   tdm_fifo #(.W(SLOT_BITS), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (slot_tail),
      .din   (rx_byte),
      .pop   (rx_ack),
      .dout  (rx_data),
      .level (rx_cnt)
   );

   assign tx_empty = (tx_cnt == '0);
   assign rx_full  = (rx_cnt == CNT_W'(FIFO_DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh  <= '1;
         rx_sh  <= '0;
         tx_unf <= 1'b0;
         rx_ovf <= 1'b0;
      end else begin
         if (slot_head) begin
            if (tx_slot_ok && !tx_empty) tx_sh <= tx_head;
            else                         tx_sh <= '1;
            if (tx_slot_ok && tx_empty)  tx_unf <= 1'b1;
         end else if (start_ev) begin
            tx_sh <= {tx_sh[SLOT_BITS-2:0], 1'b1};
         end
         if (fall_ev) rx_sh <= rx_byte;
         if (slot_tail && rx_full) rx_ovf <= 1'b1;
      end
   end

   assign sclk   = run & ~low_half;
   assign fsync  = run & (bit_idx == '0);
   assign sdo    = run ? tx_sh[SLOT_BITS-1] : 1'b1;
   assign tx_req = tx_cnt <= CNT_W'(HALF_LVL);
   assign rx_req = rx_cnt >= CNT_W'(HALF_LVL);
endmodule

// File: rtl/tdm_highway_chk.sv
module tdm_highway_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic sclk,
   input logic fsync,
   input logic sdo,
   input logic tx_req,
   input logic rx_req,
   input logic tx_unf,
   input logic rx_ovf
);
   assert_idle_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!sclk && !fsync && sdo));

   assert_sync_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fsync) |-> sclk);

   assert_sdo_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && !$rose(sclk)) |-> $stable(sdo));

   assert_unf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_unf |=> tx_unf);

   assert_unf_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_unf) |-> $past(tx_req));

   assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovf |=> rx_ovf);

   assert_ovf_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ovf) |-> $past(rx_req));
endmodule

bind tdm_highway tdm_highway_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .en     (en),
   .sclk   (sclk),
   .fsync  (fsync),
   .sdo    (sdo),
   .tx_req (tx_req),
   .rx_req (rx_req),
   .tx_unf (tx_unf),
   .rx_ovf (rx_ovf)
);

// File: tb/tb_tdm_highway.sv
module tb_tdm_highway;
   localparam int DIV_W = 8;
   localparam int CH_W  = 6;
   localparam int FRM_W = 10;

   logic             clk = 1'b0;
   logic             rst_n, en, sdi, tx_ack, rx_ack;
   logic [DIV_W-1:0] cfg_half;
   logic [FRM_W-1:0] cfg_frame;
   logic [CH_W-1:0]  cfg_chan;
   logic [7:0]       tx_data, rx_data;
   logic             sclk, fsync, sdo, tx_req, rx_req, tx_unf, rx_ovf;

   always #(10ns) clk = ~clk;

   tdm_highway dut (
      .clk(clk), .rst_n(rst_n), .en(en),
      .cfg_half(cfg_half), .cfg_frame(cfg_frame), .cfg_chan(cfg_chan),
      .sclk(sclk), .fsync(fsync), .sdo(sdo), .sdi(sdi),
      .tx_req(tx_req), .tx_ack(tx_ack), .tx_data(tx_data),
      .rx_req(rx_req), .rx_ack(rx_ack), .rx_data(rx_data),
      .tx_unf(tx_unf), .rx_ovf(rx_ovf)
   );

   int   tests = 0;
   int   fails = 0;
   int   mode  = 1;
   bit   done  = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   // behavioural reference state
   logic [7:0] txq[$];
   logic [7:0] rxq[$];
   bit         run_m = 1'b0, unf_m = 1'b0, ovf_m = 1'b0;
   int         k = 0, nb = 0;
   logic [7:0] cur_byte = 8'hFF, rxacc = 8'h00;

   always @(posedge clk) begin : ref_model
      int pre_tx, pre_rx, hh, ff, nn, hp;
      bit tpop, rpush, head;
      if (!rst_n) begin
         txq.delete(); rxq.delete();
         run_m = 1'b0; unf_m = 1'b0; ovf_m = 1'b0;
         k = 0; nb = 0; cur_byte = 8'hFF; rxacc = 8'h00;
      end else begin
         pre_tx = txq.size(); pre_rx = rxq.size();
         tpop = 1'b0; rpush = 1'b0; head = 1'b0;
         hh = int'(cfg_half) + 1; ff = int'(cfg_frame) + 1; nn = int'(cfg_chan) + 1;
         if (!en) begin
            run_m = 1'b0;
         end else if (!run_m) begin
            run_m = 1'b1; k = 0; nb = 0; head = 1'b1;
         end else begin
            hp = k / hh;
            if ((k + 1) % hh == 0) begin
               if (hp % 2 == 0) begin
                  rxacc = {rxacc[6:0], sdi};
                  if (nb % 8 == 7 && nb / 8 < nn) rpush = 1'b1;
               end else begin
                  nb = (nb + 1) % ff;
                  head = 1'b1;
               end
            end
            k++;
         end
         if (head && nb % 8 == 0) begin
            if (nb / 8 < nn) begin
               if (pre_tx > 0) begin tpop = 1'b1; cur_byte = txq[0]; end
               else begin cur_byte = 8'hFF; unf_m = 1'b1; end
            end else begin
               cur_byte = 8'hFF;
            end
         end
         if (tpop) void'(txq.pop_front());
         if (tx_ack && pre_tx < 4) txq.push_back(tx_data);
         if (rx_ack && pre_rx > 0) void'(rxq.pop_front());
         if (rpush) begin
            if (pre_rx < 4) rxq.push_back(rxacc);
            else            ovf_m = 1'b1;
         end
      end
   end

   task automatic chk(input string tag, input string name,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, name, act, exp, $time);
      end
   endtask

   task automatic compare();
      int  hh;
      bit  e_sclk;
      hh = int'(cfg_half) + 1;
      e_sclk = run_m && ((k / hh) % 2 == 0);
      chk(run_m ? "R1" : "R9", "sclk", 32'(sclk), 32'(e_sclk));
      chk(run_m ? "R2" : "R9", "fsync", 32'(fsync), 32'(run_m && nb == 0));
      chk(run_m ? (mode == 2 ? "R8" : "R3") : "R9", "sdo", 32'(sdo),
          32'(run_m ? cur_byte[7 - nb % 8] : 1'b1));
      chk("R5", "tx_req", 32'(tx_req), 32'(txq.size() <= 2));
      chk("R5", "rx_req", 32'(rx_req), 32'(rxq.size() >= 2));
      chk("R6", "tx_unf", 32'(tx_unf), 32'(unf_m));
      chk("R7", "rx_ovf", 32'(rx_ovf), 32'(ovf_m));
      if (rxq.size() > 0)
         chk(mode == 2 ? "R8" : "R4", "rx_data", 32'(rx_data), 32'(rxq[0]));
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare();
         case (mode)
            0:       begin tx_ack = tx_req; rx_ack = rx_req; end
            1:       begin tx_ack = 1'b0;   rx_ack = 1'b0;   end
            default: begin tx_ack = 1'b1;   rx_ack = 1'b1;   end
         endcase
         tx_data = tx_data + 8'd37;
         lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         sdi     = lfsr[0];
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R1 watchdog actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : stim
      rst_n = 1'b0; en = 1'b0; sdi = 1'b0; tx_ack = 1'b0; rx_ack = 1'b0;
      tx_data = 8'h11;
      cfg_half = 8'd1; cfg_frame = 10'd23; cfg_chan = 6'd1;
      @(negedge clk); @(negedge clk);
      // R9: reset state
      mode = 1;
      step(3);
      rst_n = 1'b1;
      // prefill transmit FIFO while idle
      mode = 0;
      step(8);
      // R1..R5: 2 slots of 8 bits plus 8 idle bits per frame, 4 clocks per bit
      en = 1'b1;
      step(700);
      // R6, R7: starve both DMA paths
      mode = 1;
      step(500);
      // R9: stop mid-frame, reconfigure, restart
      en = 1'b0;
      step(20);
      cfg_half = 8'd0; cfg_frame = 10'd31; cfg_chan = 6'd3;
      // R8: acknowledge every cycle, including full and empty FIFOs
      mode = 2;
      step(10);
      en = 1'b1;
      step(700);
      en = 1'b0;
      step(20);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule